// File: doc/BRIEF.md
# Bit-Sliced Walking-Window LFSR Bank

This block runs W single-bit Fibonacci LFSRs side by side. It does not keep W shift registers. It keeps their stages in a small RAM whose words are W bits wide. Bit i of the word that holds stage k is stage k of LFSR i. One step reads two whole words, the last stage and the tap stage, and XORs them, which forms the feedback of every lane at once. The result is written as the new first stage. The stored words never move. A base pointer moves down by one slot per step, so each existing word becomes the next stage by position alone. On each step the word that leaves the last stage is presented as W output bits, one from each LFSR.

The chain length L need not be a power of two. The RAM is sized to the next power of two that holds L+1 words, and every address wraps by its natural width. The L live stages therefore form a window that walks around the buffer. The newest word always lands in the spare slot just below the window. Seeds are written one stage word at a time through a load port. A load uses the base pointer that is current when it is accepted, so it can be issued after any number of steps.

Top module: `lfsr_bank`

## Requirements
- R1: While reset is high, and until the first accepted step, `out_valid_o` is 0 and `out_word_o` is all zeros.
- R2: Each accepted step gives exactly one `out_valid_o` pulse, high in the cycle right after the strobe cycle. `out_valid_o` is low in every other cycle.
- R3: Bit i of `out_word_o` is the output of LFSR i: the value its stage L held just before that step. `out_word_o` keeps its value between pulses.
- R4: The new stage 1 equals stage L XOR stage TAP (default L=7, TAP=6, polynomial x^7+x^6+1). The output word sequence y therefore obeys y[n+L] = y[n] XOR y[n+L-TAP].
- R5: The lanes are independent. A lane whose stages are all seeded with zero puts out only zeros while the other lanes run.
- R6: A lane with any nonzero seed repeats its L-bit state with a least period of exactly 2^L-1 steps (for a primitive tap pair).
- R7: A step can be accepted in every cycle. Back-to-back steps give the same words as widely spaced steps.
- R8: A load writes `load_data_i` into stage `load_stage_i`+1 of all lanes at once (code 0 means stage 1, code L-1 means stage L), at any pointer position. After stages 1..L are seeded with S1..SL, the next L outputs are SL, SL-1, ..., S1.
- R9: `step_i` is ignored in any cycle in which `load_en_i` is high. `load_en_i` is ignored in a cycle in which `out_valid_o` is high, because that cycle carries the feedback write.
- R10: The feedback word is written into the slot exactly L addresses below the last-stage address read for the same step, modulo the buffer depth. That slot is never one of the live stages that are read in the same cycle. The buffer depth is the smallest power of two that is at least L+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance every LFSR by one step |
| load_en_i | input | 1 | Write one stage word from the load port |
| load_stage_i | input | clog2(L) | Stage to load, 0 = stage 1; codes L and above are ignored |
| load_data_i | input | W | Stage word, bit i goes to lane i |
| out_word_o | output | W | Output bits of all lanes from the latest step |
| out_valid_o | output | 1 | One-cycle pulse marking a new output word |

## Verification
The bench builds two copies side by side. One is the default: 8 lanes, L=7, TAP=6, where the 7-stage window fills all but one slot of an 8-word buffer. The other has 4 lanes, L=5, TAP=3, so a 5-stage window walks through the same 8-word buffer with three spare slots. Together they cover the tight case and the loose case of the masked wrap. The short periods, 127 and 31, let the bench observe a full cycle of every lane and check that its least period is exact. The long runs carry the base pointer around the buffer many times before the mid-run reseed.

// File: rtl/lfsr_bank_pkg.sv
package lfsr_bank_pkg;

  // Address bits of the buffer: room for L live stages plus one spare slot
  // that receives the next feedback word.
  function automatic int unsigned window_addr_bits(input int unsigned len);
    return $clog2(len + 1);
  endfunction

endpackage

// File: rtl/lfsr_bank_ptr.sv
module lfsr_bank_ptr #(
  parameter int unsigned L   = 7,
  parameter int unsigned TAP = 6,
  parameter int unsigned AW  = 3,
  parameter int unsigned SW  = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          step_fire_i,
  input  logic [SW-1:0] load_stage_i,
  output logic [AW-1:0] rd_last_addr_o,
  output logic [AW-1:0] rd_tap_addr_o,
  output logic [AW-1:0] new_slot_addr_o,
  output logic [AW-1:0] load_addr_o
);

  localparam logic [AW-1:0] LAST_OFS = AW'(L - 1);
  localparam logic [AW-1:0] TAP_OFS  = AW'(TAP - 1);

  // Base points at stage 1. Moving it down by one turns every stored word
  // into the next stage without touching the data. All sums wrap at AW bits,
  // which is the power-of-two mask of the buffer.
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_q <= '0;
    end else if (step_fire_i) begin
      base_q <= base_q - 1'b1;
    end
  end

  assign rd_last_addr_o  = base_q + LAST_OFS;
  assign rd_tap_addr_o   = base_q + TAP_OFS;
  assign new_slot_addr_o = base_q - 1'b1;
  assign load_addr_o     = base_q + AW'(load_stage_i);

endmodule

// File: rtl/lfsr_bank_ram.sv
module lfsr_bank_ram #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_a_addr_i,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [W-1:0]  rd_a_data_o,
  output logic [W-1:0]  rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // Synchronous reads with a resettable output register. Port A is the last
  // stage and also drives the block output, so it keeps its value until the
  // next step.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_a_data_o <= '0;
      rd_b_data_o <= '0;
    end else if (rd_en_i) begin
      rd_a_data_o <= mem_q[rd_a_addr_i];
      rd_b_data_o <= mem_q[rd_b_addr_i];
    end
  end

endmodule

// File: rtl/lfsr_bank_fb.sv
module lfsr_bank_fb #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          step_fire_i,
  input  logic [AW-1:0] new_slot_addr_i,
  input  logic [W-1:0]  last_word_i,
  input  logic [W-1:0]  tap_word_i,
  output logic          fb_wr_en_o,
  output logic [AW-1:0] fb_wr_addr_o,
  output logic [W-1:0]  fb_wr_data_o,
  output logic          out_valid_o
);

  logic          pend_q;
  logic [AW-1:0] slot_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= 1'b0;
      slot_q <= '0;
    end else begin
      pend_q <= step_fire_i;
      if (step_fire_i) begin
        slot_q <= new_slot_addr_i;
      end
    end
  end

  // The read data arrive in the cycle after the step; the XOR of the two tap
  // words is written back in that same cycle.
  assign fb_wr_en_o   = pend_q;
  assign fb_wr_addr_o = slot_q;
  assign fb_wr_data_o = last_word_i ^ tap_word_i;
  assign out_valid_o  = pend_q;

endmodule

// File: rtl/lfsr_bank.sv
module lfsr_bank #(
  parameter int unsigned W   = 8,
  parameter int unsigned L   = 7,
  parameter int unsigned TAP = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 step_i,
  input  logic                 load_en_i,
  input  logic [$clog2(L)-1:0] load_stage_i,
  input  logic [W-1:0]         load_data_i,
  output logic [W-1:0]         out_word_o,
  output logic                 out_valid_o
);

  localparam int unsigned AW = lfsr_bank_pkg::window_addr_bits(L);
  localparam int unsigned SW = $clog2(L);

  logic          step_fire;
  logic          load_fire;
  logic [AW-1:0] rd_last_addr;
  logic [AW-1:0] rd_tap_addr;
  logic [AW-1:0] new_slot_addr;
  logic [AW-1:0] load_addr;
  logic [W-1:0]  last_word;
  logic [W-1:0]  tap_word;
  logic          fb_wr_en;
  logic [AW-1:0] fb_wr_addr;
  logic [W-1:0]  fb_wr_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data;

  // A load wins over a step. The feedback write owns the single write port,
  // so a load that coincides with it is dropped.
  assign step_fire = step_i && !load_en_i;
  assign load_fire = load_en_i && !fb_wr_en && (32'(load_stage_i) < L);

  lfsr_bank_ptr #(.L(L), .TAP(TAP), .AW(AW), .SW(SW)) u_ptr (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .step_fire_i     (step_fire),
    .load_stage_i    (load_stage_i),
    .rd_last_addr_o  (rd_last_addr),
    .rd_tap_addr_o   (rd_tap_addr),
    .new_slot_addr_o (new_slot_addr),
    .load_addr_o     (load_addr)
  );

  assign wr_en   = fb_wr_en || load_fire;
  assign wr_addr = fb_wr_en ? fb_wr_addr : load_addr;
  assign wr_data = fb_wr_en ? fb_wr_data : load_data_i;

  lfsr_bank_ram #(.W(W), .AW(AW)) u_ram (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .rd_en_i     (step_fire),
    .rd_a_addr_i (rd_last_addr),
    .rd_b_addr_i (rd_tap_addr),
    .rd_a_data_o (last_word),
    .rd_b_data_o (tap_word),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data)
  );

  lfsr_bank_fb #(.W(W), .AW(AW)) u_fb (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .step_fire_i     (step_fire),
    .new_slot_addr_i (new_slot_addr),
    .last_word_i     (last_word),
    .tap_word_i      (tap_word),
    .fb_wr_en_o      (fb_wr_en),
    .fb_wr_addr_o    (fb_wr_addr),
    .fb_wr_data_o    (fb_wr_data),
    .out_valid_o     (out_valid_o)
  );

  assign out_word_o = last_word;

endmodule

// File: rtl/lfsr_bank_chk.sv
module lfsr_bank_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned L  = 7,
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          step_i,
  input logic          load_en_i,
  input logic [W-1:0]  out_word_o,
  input logic          out_valid_o,
  input logic          rd_en,
  input logic [AW-1:0] rd_last_addr,
  input logic [AW-1:0] rd_tap_addr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);

  assert_reset_clears_R1: assert property (@(posedge clk_i)
    rst_i |=> (!out_valid_o && out_word_o == '0));

  assert_valid_follows_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !load_en_i) |=> out_valid_o);

  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !(step_i && !load_en_i) |=> !out_valid_o);

  assert_word_held_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !out_valid_o |-> $stable(out_word_o));

  assert_load_blocks_step_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    load_en_i |=> !out_valid_o);

  assert_no_live_overwrite_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en && rd_en) |-> (wr_addr != rd_last_addr && wr_addr != rd_tap_addr));

  assert_slot_below_window_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    out_valid_o |-> (wr_addr == AW'($past(rd_last_addr) - AW'(L))));

endmodule

bind lfsr_bank lfsr_bank_chk #(.W(W), .L(L), .AW(AW)) chk_i (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .step_i       (step_i),
  .load_en_i    (load_en_i),
  .out_word_o   (out_word_o),
  .out_valid_o  (out_valid_o),
  .rd_en        (step_fire),
  .rd_last_addr (rd_last_addr),
  .rd_tap_addr  (rd_tap_addr),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr)
);

// File: tb/lfsr_bank_tb_top.sv
module lfsr_bank_harness #(
  parameter int unsigned W   = 8,
  parameter int unsigned L   = 7,
  parameter int unsigned TAP = 6,
  parameter int unsigned ID  = 0
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   checks,
  output int   errors
);

  localparam int unsigned SW     = $clog2(L);
  localparam int unsigned PERIOD = (1 << L) - 1;
  localparam int unsigned HN     = 1024;

  logic          step;
  logic          load_en;
  logic [SW-1:0] load_stage;
  logic [W-1:0]  load_data;
  logic [W-1:0]  out_word;
  logic          out_valid;

  lfsr_bank #(.W(W), .L(L), .TAP(TAP)) dut_i (
    .clk_i        (clk),
    .rst_i        (rst),
    .step_i       (step),
    .load_en_i    (load_en),
    .load_stage_i (load_stage),
    .load_data_i  (load_data),
    .out_word_o   (out_word),
    .out_valid_o  (out_valid)
  );

  // Scalar reference: lane_q[i][k-1] is stage k of LFSR i.
  logic [L-1:0] lane_q [W];
  logic [W-1:0] exp_w  [HN];
  logic [W-1:0] obs    [HN];
  logic [W-1:0] stage_w [L+1];
  int exp_n;
  int obs_n;
  int cmp_idx;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (obs_n < HN) obs[obs_n] <= out_word;
      obs_n <= obs_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [L=%0d] %s: actual %h expected %h", tag, L, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int salt, input int s);
    logic [31:0] h;
    h = (32'(salt) * 32'h9E37_79B1) ^ (32'(s) * 32'h85EB_CA77);
    h = h ^ (h >> 13);
    h = h * 32'hC2B2_AE35;
    return h[W-1:0];
  endfunction

  task automatic ref_step();
    logic [W-1:0] o;
    for (int i = 0; i < W; i++) begin
      o[i] = lane_q[i][L-1];
      lane_q[i] = {lane_q[i][L-2:0], lane_q[i][L-1] ^ lane_q[i][TAP-1]};
    end
    if (exp_n < HN) exp_w[exp_n] = o;
    exp_n++;
  endtask

  task automatic load_one(input int s, input logic [W-1:0] d, input bit apply);
    @(negedge clk);
    load_en    = 1'b1;
    load_stage = SW'(s - 1);
    load_data  = d;
    if (apply) begin
      for (int i = 0; i < W; i++) lane_q[i][s-1] = d[i];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic seed_all(input int salt, input bit zero_lane0, input bit last_ones);
    for (int s = 1; s <= L; s++) begin
      logic [W-1:0] d;
      d = pat(salt, s);
      if (zero_lane0) d[0] = 1'b0;
      if (last_ones && s == L) d = '1;
      stage_w[s] = d;
      load_one(s, d, 1'b1);
    end
  endtask

  task automatic run_steps(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      step = 1'b1;
      ref_step();
      repeat (gap) begin
        @(negedge clk);
        step = 1'b0;
      end
    end
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic settle(input string tag);
    repeat (3) @(negedge clk);
    chk(obs_n == exp_n, "R2", "valid pulse count", 32'(obs_n), 32'(exp_n));
    for (int idx = cmp_idx; idx < exp_n && idx < HN; idx++) begin
      chk(obs[idx] == exp_w[idx], tag, $sformatf("output word %0d", idx),
          32'(obs[idx]), 32'(exp_w[idx]));
    end
    cmp_idx = exp_n;
  endtask

  task automatic check_recur(input int b, input int n);
    for (int k = b; k + L < b + n; k++) begin
      chk(obs[k+L] == (obs[k] ^ obs[k+L-TAP]), "R4", $sformatf("recurrence at %0d", k),
          32'(obs[k+L]), 32'(obs[k] ^ obs[k+L-TAP]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 32'd0);
    chk(out_word == '0, "R1", "word after reset", 32'(out_word), 32'd0);
  endtask

  task automatic t_readout();
    int b;
    seed_all(11, 1'b0, 1'b0);
    b = exp_n;
    run_steps(L, 1);
    settle("R3");
    for (int j = 0; j < L; j++) begin
      chk(obs[b+j] == stage_w[L-j], "R8", $sformatf("seed readout %0d", j),
          32'(obs[b+j]), 32'(stage_w[L-j]));
    end
  endtask

  task automatic t_lanes();
    int b;
    seed_all(23, 1'b1, 1'b0);
    b = exp_n;
    run_steps(40, 2);
    settle("R3");
    for (int k = b; k < b + 40; k++) begin
      chk(obs[k][0] == 1'b0, "R5", $sformatf("zero lane at %0d", k), 32'(obs[k][0]), 32'd0);
    end
    check_recur(b, 40);
  endtask

  task automatic t_back_to_back();
    int b;
    seed_all(37, 1'b0, 1'b1);
    b = exp_n;
    run_steps(60, 0);
    settle("R7");
    check_recur(b, 60);
  endtask

  task automatic t_period();
    int b;
    seed_all(41, 1'b0, 1'b1);
    b = exp_n;
    run_steps(PERIOD + L + 4, 0);
    settle("R10");
    for (int lane = 0; lane < W; lane++) begin
      int first;
      first = 0;
      for (int d = 1; d <= PERIOD; d++) begin
        bit same;
        same = 1'b1;
        for (int j = 0; j < L; j++) begin
          if (obs[b+d+j][lane] != obs[b+j][lane]) same = 1'b0;
        end
        if (same && first == 0) first = d;
      end
      chk(first == PERIOD, "R6", $sformatf("least period of lane %0d", lane),
          32'(first), 32'(PERIOD));
    end
  endtask

  task automatic t_priority();
    logic [W-1:0] d;
    seed_all(53, 1'b0, 1'b0);
    d = pat(59, 1);
    @(negedge clk);
    load_en    = 1'b1;
    step       = 1'b1;
    load_stage = SW'(0);
    load_data  = d;
    for (int i = 0; i < W; i++) lane_q[i][0] = d[i];
    @(negedge clk);
    load_en = 1'b0;
    step    = 1'b0;
    chk(out_valid == 1'b0, "R9", "step under load ignored", 32'(out_valid), 32'd0);
    @(negedge clk);
    step = 1'b1;
    ref_step();
    @(negedge clk);
    step = 1'b0;
    chk(out_valid == 1'b1, "R2", "valid one cycle after step", 32'(out_valid), 32'd1);
    load_en    = 1'b1;
    load_stage = SW'(0);
    load_data  = ~d;
    @(negedge clk);
    load_en = 1'b0;
    settle("R9");
    run_steps(L + 2, 1);
    settle("R9");
  endtask

  task automatic t_reseed();
    int b;
    seed_all(67, 1'b0, 1'b0);
    b = exp_n;
    run_steps(L + 4, 1);
    settle("R3");
    for (int j = 0; j < L; j++) begin
      chk(obs[b+j] == stage_w[L-j], "R8", $sformatf("mid-run reseed %0d", j),
          32'(obs[b+j]), 32'(stage_w[L-j]));
    end
  endtask

  initial begin
    done       = 1'b0;
    checks     = 0;
    errors     = 0;
    step       = 1'b0;
    load_en    = 1'b0;
    load_stage = '0;
    load_data  = '0;
    exp_n      = 0;
    cmp_idx    = 0;
    for (int i = 0; i < W; i++) lane_q[i] = '0;
    @(negedge clk);
    while (rst) @(negedge clk);
    t_reset();
    t_readout();
    t_lanes();
    t_back_to_back();
    t_period();
    t_priority();
    t_reseed();
    done = 1'b1;
  end

  initial obs_n = 0;

endmodule

module lfsr_bank_tb_top;

  logic clk;
  logic rst;
  logic done7, done5;
  int   checks7, errors7, checks5, errors5;
  bit   wd_fired;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    rst = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  end

  lfsr_bank_harness #(.W(8), .L(7), .TAP(6), .ID(0)) h_len7 (
    .clk (clk), .rst (rst), .done (done7), .checks (checks7), .errors (errors7)
  );

  lfsr_bank_harness #(.W(4), .L(5), .TAP(3), .ID(1)) h_len5 (
    .clk (clk), .rst (rst), .done (done5), .checks (checks5), .errors (errors5)
  );

  initial begin
    int total_checks;
    int total_errors;
    wd_fired = 1'b0;
    fork
      begin
        wait (done7 === 1'b1 && done5 === 1'b1);
      end
      begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
      end
    join_any
    total_checks = checks7 + checks5;
    total_errors = errors7 + errors5;
    if (wd_fired) begin
      total_checks++;
      total_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", total_checks, total_errors);
    $finish;
  end

endmodule